// File: doc/BRIEF.md
# Two-Channel Host Register Bank with Broadcast Write

This block is the host-side register interface of a two-channel serial controller. A host presents an address, write data, a read strobe, a write strobe and a channel-select bit. Each channel keeps its own set of control registers, and the two channels share one alternate-function register. The serial datapaths, FIFOs and baud generation are not part of the block. Their baud clock and receive-ready indications arrive as plain inputs.

The shared register has two uses. Its lowest bit turns on a broadcast mode, in which one host write updates the addressed register in every channel at the same time, while reads still follow channel select. Its two select bits choose what drives each channel's active-low multi-function pin: the channel's output-control level, its baud clock, its receive-ready indication, or a fixed inactive level.

Register slots 0 to 2 are banked by bit 7 of each channel's line-control register. With the bit clear, they hold three general registers. With the bit set, they hold the divisor low byte, the divisor high byte and a fractional register. Reading the divisor high slot returns a fixed device identifier when both divisor bytes of that channel are zero.

Top module: `dual_chan_regbank`

## Requirements
- R1: After reset, every register reads 0x00 and every multi-function pin is high (inactive).
- R2: With broadcast off (alternate-function bit 0 = 0), a write changes only the register of the channel selected by `chan_sel`.
- R3: With broadcast on (alternate-function bit 0 = 1), a single write updates the addressed register in both channels.
- R4: With broadcast on, a read returns the register of the channel selected by `chan_sel`.
- R5: The alternate-function register is at address 6 and is shared. It can be read and written with either value of `chan_sel`. Bits 7:3 always read 0 and ignore writes.
- R6: Addresses 0, 1 and 2 are banked by bit 7 of the channel's own line-control register (address 3). Bit 7 = 0 selects the general registers. Bit 7 = 1 selects divisor low, divisor high and fractional. During a broadcast write, each channel decodes the write using its own bank bit.
- R7: With bank bit = 1, a read of address 1 returns the identifier 0x02 when both divisor bytes of the selected channel are 0x00, whatever the fractional value. Otherwise it returns the divisor high byte.
- R8: The fractional register keeps bits 5:0 only. Bits 7:6 read 0.
- R9: Alternate-function bits 2:1 select the source of `mf_n[c]`:
  - 00: the inverse of bit 3 of the channel's output-control register (address 4);
  - 01: the inverse of `baud_clk[c]`;
  - 10: the inverse of `rx_ready[c]`;
  - 11: constant high.
- R10: `rdata` is 0x00 whenever `rd` is low.
- R11: Address 5 is reserved: it reads 0x00 and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rd | input | 1 | Read strobe; gates `rdata` |
| wr | input | 1 | Write strobe, sampled on the clock edge |
| chan_sel | input | 1 | Channel select for reads and for writes when broadcast is off |
| baud_clk | input | 2 | Per-channel baud clock from the baud generator |
| rx_ready | input | 2 | Per-channel receive-ready indication |
| mf_n | output | 2 | Per-channel active-low multi-function pin |
| rdata | output | 8 | Read data; combinational while `rd` is high |

## Verification
The bench gives the two channels different bank states and then issues a broadcast write to slot 0. One channel's divisor byte and the other channel's general register must both change. A design that decodes the broadcast using only the selected channel's bank bit would write the same register in both channels. The identifier check is run first with the fractional register nonzero, then with one divisor byte nonzero, then with it cleared. A design that also tests the fractional register, or tests only one divisor byte, returns the wrong value in one of these reads. The reserved bits of the alternate-function and fractional registers are written as ones and read back. The reserved pin-select code must hold both pins high even while both inputs are asserted.

// File: rtl/dbank_pkg.sv
package dbank_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int BANK_BIT  = 7;
    localparam int OP2_BIT   = 3;
    localparam int FRAC_W    = 6;
    localparam logic [DATA_W-1:0] DEVICE_ID = 8'h02;

    typedef enum logic [ADDR_W-1:0] {
        A_SLOT0   = 3'd0,
        A_SLOT1   = 3'd1,
        A_SLOT2   = 3'd2,
        A_LINE    = 3'd3,
        A_OUTCTL  = 3'd4,
        A_RSVD    = 3'd5,
        A_ALTFN   = 3'd6,
        A_SCRATCH = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        MF_OP2   = 2'b00,
        MF_BAUD  = 2'b01,
        MF_RXRDY = 2'b10,
        MF_OFF   = 2'b11
    } mf_sel_e;

    typedef struct packed {
        logic [4:0] rsvd;
        mf_sel_e    mf_sel;
        logic       bcast;
    } altfn_t;

    function automatic logic mf_pin_level(mf_sel_e sel, logic op2, logic baud, logic rxr);
        logic lvl;
        case (sel)
            MF_OP2:   lvl = ~op2;
            MF_BAUD:  lvl = ~baud;
            MF_RXRDY: lvl = ~rxr;
            default:  lvl = 1'b1;
        endcase
        return lvl;
    endfunction

    function automatic altfn_t altfn_from_bus(logic [DATA_W-1:0] d);
        altfn_t a;
        a.rsvd   = '0;
        a.mf_sel = mf_sel_e'(d[2:1]);
        a.bcast  = d[0];
        return a;
    endfunction

endpackage

// File: rtl/dbank_chan_regs.sv
module dbank_chan_regs
    import dbank_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int AW     = ADDR_W,
    parameter int FW     = FRAC_W,
    parameter logic [DW-1:0] ID_VAL = DEVICE_ID
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_val,
    output logic          bank_o,
    output logic          op2_o
);

    logic [DW-1:0] gen0_q, gen1_q, gen2_q;
    logic [DW-1:0] div_lo_q, div_hi_q;
    logic [FW-1:0] frac_q;
    logic [DW-1:0] line_q, outctl_q, scratch_q;
    logic          bank;
    logic          div_zero;

    assign bank     = line_q[BANK_BIT];
    assign div_zero = (div_lo_q == '0) && (div_hi_q == '0);
    assign bank_o   = bank;
    assign op2_o    = outctl_q[OP2_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            gen0_q    <= '0;
            gen1_q    <= '0;
            gen2_q    <= '0;
            div_lo_q  <= '0;
            div_hi_q  <= '0;
            frac_q    <= '0;
            line_q    <= '0;
            outctl_q  <= '0;
            scratch_q <= '0;
        end else if (we) begin
            case (addr)
                A_SLOT0: begin
                    if (bank) div_lo_q <= wdata;
                    else      gen0_q   <= wdata;
                end
                A_SLOT1: begin
                    if (bank) div_hi_q <= wdata;
                    else      gen1_q   <= wdata;
                end
                A_SLOT2: begin
                    if (bank) frac_q <= wdata[FW-1:0];
                    else      gen2_q <= wdata;
                end
                A_LINE:    line_q    <= wdata;
                A_OUTCTL:  outctl_q  <= wdata;
                A_SCRATCH: scratch_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_val = '0;
        case (addr)
            A_SLOT0:   rd_val = bank ? div_lo_q : gen0_q;
            A_SLOT1:   rd_val = bank ? (div_zero ? ID_VAL : div_hi_q) : gen1_q;
            A_SLOT2:   rd_val = bank ? DW'(frac_q) : gen2_q;
            A_LINE:    rd_val = line_q;
            A_OUTCTL:  rd_val = outctl_q;
            A_SCRATCH: rd_val = scratch_q;
            default:   rd_val = '0;
        endcase
    end

endmodule

// File: rtl/dbank_altfn_reg.sv
module dbank_altfn_reg
    import dbank_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output altfn_t        afr_o
);

    altfn_t afr_q;

    always_ff @(posedge clk) begin
        if (rst)     afr_q <= '0;
        else if (we) afr_q <= altfn_from_bus(wdata);
    end

    assign afr_o = afr_q;

endmodule

// File: rtl/dbank_mf_out.sv
module dbank_mf_out
    import dbank_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  mf_sel_e           sel,
    input  logic [NUM_CH-1:0] op2,
    input  logic [NUM_CH-1:0] baud,
    input  logic [NUM_CH-1:0] rxr,
    output logic [NUM_CH-1:0] mf_n
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_pin
        assign mf_n[c] = mf_pin_level(sel, op2[c], baud[c], rxr[c]);
    end

endmodule

// File: rtl/dual_chan_regbank.sv
module dual_chan_regbank
    import dbank_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DW     = DATA_W,
    parameter int AW     = ADDR_W,
    parameter logic [DW-1:0] ID_VAL = DEVICE_ID,
    localparam int CSW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic              rd,
    input  logic              wr,
    input  logic [CSW-1:0]    chan_sel,
    input  logic [NUM_CH-1:0] baud_clk,
    input  logic [NUM_CH-1:0] rx_ready,
    output logic [NUM_CH-1:0] mf_n,
    output logic [DW-1:0]     rdata
);

    altfn_t            afr_q;
    logic              afr_hit;
    logic [NUM_CH-1:0] chan_we;
    logic [NUM_CH-1:0] bank_q;
    logic [NUM_CH-1:0] op2_q;
    logic [DW-1:0]     chan_rd [NUM_CH];

    assign afr_hit = (addr == A_ALTFN);

    dbank_altfn_reg #(.DW(DW)) u_afr (
        .clk   (clk),
        .rst   (rst),
        .we    (wr && afr_hit),
        .wdata (wdata),
        .afr_o (afr_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign chan_we[g] = wr && !afr_hit && (afr_q.bcast || (chan_sel == CSW'(g)));

        dbank_chan_regs #(.DW(DW), .AW(AW), .ID_VAL(ID_VAL)) u_regs (
            .clk    (clk),
            .rst    (rst),
            .we     (chan_we[g]),
            .addr   (addr),
            .wdata  (wdata),
            .rd_val (chan_rd[g]),
            .bank_o (bank_q[g]),
            .op2_o  (op2_q[g])
        );
    end

    dbank_mf_out #(.NUM_CH(NUM_CH)) u_mf (
        .sel  (afr_q.mf_sel),
        .op2  (op2_q),
        .baud (baud_clk),
        .rxr  (rx_ready),
        .mf_n (mf_n)
    );

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (afr_hit) rdata = DW'(afr_q);
            else         rdata = chan_rd[chan_sel];
        end
    end

endmodule

// File: rtl/dual_chan_regbank_chk.sv
module dual_chan_regbank_chk
    import dbank_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DW     = DATA_W,
    parameter int AW     = ADDR_W,
    parameter int CSW    = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              rd,
    input logic              wr,
    input logic [AW-1:0]     addr,
    input logic [CSW-1:0]    chan_sel,
    input logic [DW-1:0]     rdata,
    input logic [NUM_CH-1:0] mf_n,
    input altfn_t            afr,
    input logic [NUM_CH-1:0] bank
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (afr == '0 && mf_n == '1 && bank == '0));

    p_single_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && !afr.bcast && addr == A_LINE && chan_sel == '0) |=> $stable(bank[NUM_CH-1]));

    p_broadcast_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && afr.bcast && addr == A_LINE) |=> (bank == '0 || bank == '1));

    p_afr_reserved_r5: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_ALTFN) |-> (rdata[DW-1:3] == '0));

    p_mf_off_r9: assert property (@(posedge clk) disable iff (rst)
        (afr.mf_sel == MF_OFF) |-> (mf_n == '1));

    p_idle_read_r10: assert property (@(posedge clk) disable iff (rst)
        !rd |-> (rdata == '0));

    p_reserved_addr_r11: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_RSVD) |-> (rdata == '0));

endmodule

bind dual_chan_regbank dual_chan_regbank_chk #(
    .NUM_CH (NUM_CH),
    .DW     (DW),
    .AW     (AW),
    .CSW    (CSW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd       (rd),
    .wr       (wr),
    .addr     (addr),
    .chan_sel (chan_sel),
    .rdata    (rdata),
    .mf_n     (mf_n),
    .afr      (afr_q),
    .bank     (bank_q)
);

// File: tb/test_dual_chan_regbank.sv
`timescale 1ns/1ps
module test_dual_chan_regbank;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [0:0] chan_sel = '0;
    logic [1:0] baud_clk = '0;
    logic [1:0] rx_ready = '0;
    logic [1:0] mf_n;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    dual_chan_regbank i_dual_chan_regbank (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .wdata    (wdata),
        .rd       (rd),
        .wr       (wr),
        .chan_sel (chan_sel),
        .baud_clk (baud_clk),
        .rx_ready (rx_ready),
        .mf_n     (mf_n),
        .rdata    (rdata)
    );

    // monitor: compares each read strobe against the scoreboard
    always @(negedge clk) begin
        if (!rst && rd) begin
            logic [7:0] e;
            string      t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with no expected item, actual %02h", rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", t, rdata, e);
                end
            end
        end
    end

    task automatic do_write(input logic ch, input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        chan_sel = ch; addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic do_read(input logic ch, input logic [2:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        chan_sel = ch; addr = a; rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic chk_pins(input logic [1:0] e, input string t);
        @(negedge clk);
        checks++;
        if (mf_n !== e) begin
            errors++;
            $display("FAIL %s: mf_n actual %b expected %b", t, mf_n, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        do_read(0, 3'd3, 8'h00, "R1 line A");
        do_read(1, 3'd6, 8'h00, "R1 altfn");
        do_read(1, 3'd7, 8'h00, "R1 scratch B");
        chk_pins(2'b11, "R1 pins");

        // R2 single channel write
        do_write(0, 3'd7, 8'h5A);
        do_read(0, 3'd7, 8'h5A, "R2 scratch A");
        do_read(1, 3'd7, 8'h00, "R2 scratch B untouched");

        // R5 reserved bits of shared register, written through channel B
        do_write(1, 3'd6, 8'hFF);
        do_read(0, 3'd6, 8'h07, "R5 altfn via A");
        chk_pins(2'b11, "R9 reserved select");

        // R3 broadcast
        do_write(0, 3'd7, 8'h33);
        do_read(0, 3'd7, 8'h33, "R3 scratch A");
        do_read(1, 3'd7, 8'h33, "R3 scratch B");

        // R4 reads follow chan_sel in broadcast mode
        do_write(0, 3'd6, 8'h00);
        do_write(1, 3'd7, 8'h44);
        do_write(1, 3'd6, 8'hF9);
        do_read(0, 3'd6, 8'h01, "R5 altfn mask");
        do_read(0, 3'd7, 8'h33, "R4 read A");
        do_read(1, 3'd7, 8'h44, "R4 read B");

        // R6 banking per channel
        do_write(0, 3'd6, 8'h00);
        do_write(0, 3'd3, 8'h80);
        do_write(0, 3'd6, 8'h01);
        do_write(0, 3'd0, 8'h12);
        do_read(0, 3'd0, 8'h12, "R6 divisor low A");
        do_read(0, 3'd3, 8'h80, "R6 line A");
        do_write(1, 3'd3, 8'h80);
        do_read(1, 3'd0, 8'h00, "R6 divisor low B");
        do_read(0, 3'd0, 8'h12, "R6 divisor low A kept");

        // R7 identifier, R8 fractional
        do_write(0, 3'd2, 8'hFF);
        do_read(1, 3'd1, 8'h02, "R7 id B");
        do_read(0, 3'd1, 8'h00, "R7 divisor high A");
        do_read(0, 3'd2, 8'h3F, "R8 frac A");
        do_write(1, 3'd0, 8'h00);
        do_read(0, 3'd1, 8'h02, "R7 id A");
        do_write(0, 3'd1, 8'h05);
        do_read(1, 3'd1, 8'h05, "R7 divisor high B");

        do_write(0, 3'd3, 8'h00);
        do_read(0, 3'd0, 8'h00, "R6 general A");
        do_read(1, 3'd0, 8'h12, "R6 general B");

        // R10 idle read
        @(posedge clk); #1;
        addr = 3'd7; chan_sel = 1'b1;
        @(negedge clk);
        checks++;
        if (rdata !== 8'h00) begin
            errors++;
            $display("FAIL R10: actual %02h expected 00", rdata);
        end

        // R11 reserved address
        do_write(0, 3'd5, 8'hAA);
        do_read(0, 3'd5, 8'h00, "R11 reserved A");
        do_read(1, 3'd5, 8'h00, "R11 reserved B");

        // R9 pin sources
        do_write(0, 3'd6, 8'h00);
        do_write(0, 3'd4, 8'h08);
        chk_pins(2'b10, "R9 op2");
        do_write(0, 3'd6, 8'h02);
        baud_clk = 2'b01;
        chk_pins(2'b10, "R9 baud 01");
        baud_clk = 2'b10;
        chk_pins(2'b01, "R9 baud 10");
        do_write(0, 3'd6, 8'h04);
        rx_ready = 2'b11;
        chk_pins(2'b00, "R9 rxrdy 11");
        rx_ready = 2'b01;
        chk_pins(2'b10, "R9 rxrdy 01");
        do_write(0, 3'd6, 8'h06);
        rx_ready = 2'b11; baud_clk = 2'b11;
        chk_pins(2'b11, "R9 off");

        @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule